// File: doc/BRIEF.md
# Packet Header Error Check and Repair

This block sits after lane merging in a camera serial link receiver. Each packet header (long-packet header or short packet) reaches it as one 32-bit word with a valid strobe. The block recomputes the six check bits over the 24 protected header bits and compares them with the check bits that arrived with the header. From the difference (the syndrome) it works out one of three cases: the header is clean, one bit flipped and can be repaired, or the damage cannot be repaired.

One clock later the block presents the repaired header as separate fields: virtual channel, data type and the 16-bit word count or short-packet data. With these fields it gives a one-cycle pulse that says whether a repair was made or the header could not be repaired. Two saturating event counters and a sticky uncorrectable flag feed a status register. Software clears the flag by writing a one to it.

Top module: `pkt_hdr_ecc`

## Requirements
- R1: Header word layout. Bits [7:6] are the virtual channel. Bits [5:0] are the data type. Bits [23:8] are the word count, with its low byte in [15:8]. Bits [29:24] carry the received check bits, check bit k in bit 24+k.
- R2: A header whose syndrome is zero leaves the block with every field unchanged, and neither status pulse is raised.
- R3: Protected bit i (bit i of the word, i = 0..23) contributes to check bit k when bit k of its column code is set. The codes for i = 0 to 23 are, in hex: 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B. Each check bit is the XOR of its contributors. When the syndrome (computed XOR received) equals the code of bit i, that bit is inverted on the output and out_corrected pulses.
- R4: When the syndrome has exactly one bit set, the error is in the check bits alone. The output fields equal the received fields and out_corrected pulses.
- R5: Any other non-zero syndrome raises out_uncorrectable without out_corrected. The output fields then carry the received bits unmodified.
- R6: The output strobe and fields appear exactly one clock after the input strobe. Without an input strobe, out_valid is low, the fields hold their last values, and no status pulse is raised.
- R7: err_sticky is set by every uncorrectable header. It holds until a clock with clr_wr high and clr_data high clears it. A clear with clr_data low has no effect. A new uncorrectable header in the same clock as a clear leaves the flag set.
- R8: corr_count counts out_corrected pulses and uncorr_count counts out_uncorrectable pulses. Both stop at their all-ones value instead of wrapping.
- R9: While rst_n is low, every output is zero.
- R10: Bits [31:30] of the header word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header word strobe |
| hdr_word | input | 32 | Received header word |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | 1 | Write data; a one clears err_sticky |
| out_valid | output | 1 | Output fields valid |
| out_vc | output | 2 | Virtual channel |
| out_dt | output | 6 | Data type |
| out_wc | output | 16 | Word count or short-packet data |
| out_corrected | output | 1 | Single-bit repair pulse |
| out_uncorrectable | output | 1 | Unrepairable header pulse |
| corr_count | output | CNT_W | Saturating count of repaired headers |
| uncorr_count | output | CNT_W | Saturating count of unrepairable headers |
| err_sticky | output | 1 | Sticky uncorrectable flag |

## Verification
The bench injects single flips in every region of the header. A flip in one of the six check bits is a trap: a design that matched the syndrome against the data columns only would report it as unrepairable, and one that decoded it as a data position would corrupt a good field. Double flips must all come out unrepairable. A decoder that took them for single-bit errors would invert a third, clean bit. The bench also sets the two unused top bits, which a design that folded them into the parity would flag as errors. It also drives a clear in the same clock as a fresh uncorrectable header, which a clear-first flag would lose, and it runs the 4-bit counters past fifteen, where a wrapping counter would read back as zero.

// File: rtl/pkt_hdr_ecc_pkg.sv
// Shared definitions for the packet header check/repair block.
// Assumes the fixed 24-data-bit, 6-check-bit header code of the link.
package pkt_hdr_ecc_pkg;

    localparam int HDR_W  = 32;
    localparam int DATA_W = 24;
    localparam int PAR_W  = 6;

    // Outcome of syndrome decoding.
    typedef enum logic [1:0] {
        SYN_CLEAN  = 2'd0,
        SYN_DATA   = 2'd1,
        SYN_PARITY = 2'd2,
        SYN_MULTI  = 2'd3
    } syn_kind_e;

    // Decoded header fields in output order.
    typedef struct packed {
        logic [15:0] wc;
        logic [1:0]  vc;
        logic [5:0]  dt;
    } hdr_fields_t;

    // Column code of protected bit idx: which check bits it feeds.
    function automatic logic [PAR_W-1:0] col_code(input int unsigned idx);
        logic [PAR_W-1:0] c;
        case (idx)
            0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
            4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
            8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
            12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
            16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
            20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pkt_hdr_ecc_syndrome.sv
// Recomputes the check bits over the protected header bits and forms
// the syndrome against the received check bits. Purely combinational.
// Assumes data and check widths from the package.
module pkt_hdr_ecc_syndrome
    import pkt_hdr_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_bits,
    input  logic [PAR_W-1:0]  rx_check,
    output logic [PAR_W-1:0]  syndrome
);

    logic [PAR_W-1:0] calc_check;

    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        // XOR together every protected bit whose column feeds check bit k.
        always_comb begin
            logic             acc;
            logic [PAR_W-1:0] code;
            acc = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                code = col_code(i);
                if (code[k]) acc = acc ^ data_bits[i];
            end
            calc_check[k] = acc;
        end
    end

    // Syndrome is the difference between computed and received checks.
    always_comb syndrome = calc_check ^ rx_check;

endmodule

// File: rtl/pkt_hdr_ecc_decode.sv
// Maps a syndrome onto a repair mask and an outcome class.
// Zero: clean. One bit set: check-bit error only. Equal to a column
// code: that data bit flipped. Anything else: unrepairable, no mask.
module pkt_hdr_ecc_decode
    import pkt_hdr_ecc_pkg::*;
(
    input  logic [PAR_W-1:0]  syndrome,
    output logic [DATA_W-1:0] flip_mask,
    output syn_kind_e         kind
);

    logic [DATA_W-1:0] hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        // Compare the syndrome against the column code of bit i.
        always_comb hit[i] = (syndrome == col_code(i));
    end

    // Classify the syndrome and release the mask only for data errors.
    always_comb begin
        flip_mask = '0;
        if (syndrome == '0) begin
            kind = SYN_CLEAN;
        end else if ($countones(syndrome) == 1) begin
            kind = SYN_PARITY;
        end else if (hit != '0) begin
            kind      = SYN_DATA;
            flip_mask = hit;
        end else begin
            kind = SYN_MULTI;
        end
    end

endmodule

// File: rtl/pkt_hdr_ecc_stats.sv
// Saturating event counters and a sticky uncorrectable flag with a
// write-one-to-clear port. A set in the same cycle as a clear wins.
module pkt_hdr_ecc_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_corr,
    input  logic             evt_uncorr,
    input  logic             clr_wr,
    input  logic             clr_data,
    output logic [CNT_W-1:0] corr_count,
    output logic [CNT_W-1:0] uncorr_count,
    output logic             err_sticky
);

    localparam int NUM_CNT = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_CNT-1:0] evt;
    assign evt = {evt_uncorr, evt_corr};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [CNT_W-1:0] q;
        // Count events of class g, holding at the top value.
        always_ff @(posedge clk) begin
            if (!rst_n)                      q <= '0;
            else if (evt[g] && q != CNT_MAX) q <= q + 1'b1;
        end
    end

    assign corr_count   = g_cnt[0].q;
    assign uncorr_count = g_cnt[1].q;

    // Sticky flag: set by an unrepairable header, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err_sticky <= 1'b0;
        else if (evt_uncorr)         err_sticky <= 1'b1;
        else if (clr_wr && clr_data) err_sticky <= 1'b0;
    end

endmodule

// File: rtl/pkt_hdr_ecc.sv
// Packet header check and repair, top level. Takes one 32-bit header per
// strobe and returns the repaired fields one clock later with status
// pulses. Assumes the check bits sit in [29:24]; bits [31:30] are unused.
module pkt_hdr_ecc
    import pkt_hdr_ecc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [31:0]      hdr_word,
    input  logic             clr_wr,
    input  logic             clr_data,
    output logic             out_valid,
    output logic [1:0]       out_vc,
    output logic [5:0]       out_dt,
    output logic [15:0]      out_wc,
    output logic             out_corrected,
    output logic             out_uncorrectable,
    output logic [CNT_W-1:0] corr_count,
    output logic [CNT_W-1:0] uncorr_count,
    output logic             err_sticky
);

    logic [DATA_W-1:0] data_bits;
    logic [PAR_W-1:0]  rx_check;
    logic [PAR_W-1:0]  syndrome;
    logic [DATA_W-1:0] flip_mask;
    syn_kind_e         kind;
    hdr_fields_t       fixed_fields;
    hdr_fields_t       fields_q;
    logic              is_corr;
    logic              is_uncorr;

    // Split the word into protected bits and received check bits.
    always_comb begin
        data_bits = hdr_word[DATA_W-1:0];
        rx_check  = hdr_word[DATA_W +: PAR_W];
    end

    pkt_hdr_ecc_syndrome u_syn (
        .data_bits (data_bits),
        .rx_check  (rx_check),
        .syndrome  (syndrome)
    );

    pkt_hdr_ecc_decode u_dec (
        .syndrome  (syndrome),
        .flip_mask (flip_mask),
        .kind      (kind)
    );

    // Apply the repair mask and classify the event for this strobe.
    always_comb begin
        fixed_fields = hdr_fields_t'(data_bits ^ flip_mask);
        is_corr      = hdr_valid && (kind == SYN_DATA || kind == SYN_PARITY);
        is_uncorr    = hdr_valid && (kind == SYN_MULTI);
    end

    // Output stage: one register, fields update only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid         <= 1'b0;
            out_corrected     <= 1'b0;
            out_uncorrectable <= 1'b0;
            fields_q          <= '0;
        end else begin
            out_valid         <= hdr_valid;
            out_corrected     <= is_corr;
            out_uncorrectable <= is_uncorr;
            if (hdr_valid) fields_q <= fixed_fields;
        end
    end

    // Present the stored fields on separate ports.
    always_comb begin
        out_vc = fields_q.vc;
        out_dt = fields_q.dt;
        out_wc = fields_q.wc;
    end

    pkt_hdr_ecc_stats #(.CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_corr     (is_corr),
        .evt_uncorr   (is_uncorr),
        .clr_wr       (clr_wr),
        .clr_data     (clr_data),
        .corr_count   (corr_count),
        .uncorr_count (uncorr_count),
        .err_sticky   (err_sticky)
    );

endmodule

// File: rtl/pkt_hdr_ecc_sva.sv
// Property checker for pkt_hdr_ecc, bound to every instance of the top.
module pkt_hdr_ecc_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_valid,
    input logic [31:0]      hdr_word,
    input logic             clr_wr,
    input logic             clr_data,
    input logic             out_valid,
    input logic [1:0]       out_vc,
    input logic [5:0]       out_dt,
    input logic [15:0]      out_wc,
    input logic             out_corrected,
    input logic             out_uncorrectable,
    input logic [CNT_W-1:0] corr_count,
    input logic [CNT_W-1:0] uncorr_count,
    input logic             err_sticky
);

    // R6
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);

    // R6
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!out_valid && !out_corrected && !out_uncorrectable));

    // R5
    status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corrected && out_uncorrectable));

    // R2
    clean_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_corrected && !out_uncorrectable)
        |-> ({out_wc, out_vc, out_dt} == $past(hdr_word[23:0])));

    // R5
    uncorr_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_uncorrectable |-> ({out_wc, out_vc, out_dt} == $past(hdr_word[23:0])));

    // R7
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_uncorrectable |-> err_sticky);

    // R7
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_sticky) |-> $past(clr_wr && clr_data));

    // R8
    corr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_corrected |-> $stable(corr_count));

    // R8
    uncorr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_uncorrectable |-> $stable(uncorr_count));

endmodule

bind pkt_hdr_ecc pkt_hdr_ecc_sva #(.CNT_W(CNT_W)) u_sva (
    .clk               (clk),
    .rst_n             (rst_n),
    .hdr_valid         (hdr_valid),
    .hdr_word          (hdr_word),
    .clr_wr            (clr_wr),
    .clr_data          (clr_data),
    .out_valid         (out_valid),
    .out_vc            (out_vc),
    .out_dt            (out_dt),
    .out_wc            (out_wc),
    .out_corrected     (out_corrected),
    .out_uncorrectable (out_uncorrectable),
    .corr_count        (corr_count),
    .uncorr_count      (uncorr_count),
    .err_sticky        (err_sticky)
);

// File: tb/pkt_hdr_ecc_tb.sv
// Self-checking bench: seeded random headers with injected flips, plus
// directed corner cases for layout, unused bits, sticky flag and counters.
module pkt_hdr_ecc_tb;

    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hdr_valid = 1'b0;
    logic [31:0]      hdr_word = '0;
    logic             clr_wr = 1'b0;
    logic             clr_data = 1'b0;
    logic             out_valid;
    logic [1:0]       out_vc;
    logic [5:0]       out_dt;
    logic [15:0]      out_wc;
    logic             out_corrected;
    logic             out_uncorrectable;
    logic [CNT_W-1:0] corr_count;
    logic [CNT_W-1:0] uncorr_count;
    logic             err_sticky;

    int checks = 0;
    int failures = 0;
    int exp_corr = 0;
    int exp_uncorr = 0;
    bit exp_sticky = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pkt_hdr_ecc #(.CNT_W(CNT_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .hdr_valid (hdr_valid), .hdr_word (hdr_word),
        .clr_wr (clr_wr), .clr_data (clr_data), .out_valid (out_valid),
        .out_vc (out_vc), .out_dt (out_dt), .out_wc (out_wc),
        .out_corrected (out_corrected), .out_uncorrectable (out_uncorrectable),
        .corr_count (corr_count), .uncorr_count (uncorr_count),
        .err_sticky (err_sticky)
    );

    // Column codes from the requirement, bit 0 first.
    function automatic logic [5:0] tb_code(input int i);
        logic [5:0] t [24] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                               6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
                               6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};
        return t[i];
    endfunction

    // Check bits over 24 data bits: XOR the codes of every set bit.
    function automatic logic [5:0] tb_ecc(input logic [23:0] d);
        logic [5:0] e = '0;
        for (int i = 0; i < 24; i++) if (d[i]) e ^= tb_code(i);
        return e;
    endfunction

    // Expected result: kind 0 clean, 1 repaired, 2 unrepairable; fixed data.
    function automatic void tb_model(input logic [31:0] w, output int kind,
                                     output logic [23:0] fixed);
        logic [5:0] s;
        s     = tb_ecc(w[23:0]) ^ w[29:24];
        fixed = w[23:0];
        if (s == 0) begin
            kind = 0;
        end else if ($countones(s) == 1) begin
            kind = 1;
        end else begin
            kind = 2;
            for (int i = 0; i < 24; i++)
                if (tb_code(i) == s) begin kind = 1; fixed[i] = ~fixed[i]; end
        end
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // Send one header, sample at the next falling edge, compare with the model.
    task automatic send(input logic [31:0] w, input string req);
        int kind;
        logic [23:0] fx;
        tb_model(w, kind, fx);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_word  = w;
        @(negedge clk);
        hdr_valid = 1'b0;
        if (kind == 1 && exp_corr < CMAX) exp_corr++;
        if (kind == 2 && exp_uncorr < CMAX) exp_uncorr++;
        if (kind == 2) exp_sticky = 1'b1;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " fields"}, {8'h0, out_wc, out_vc, out_dt}, {8'h0, fx});
        check({req, " corrected"}, 32'(out_corrected), 32'(kind == 1));
        check({req, " uncorrectable"}, 32'(out_uncorrectable), 32'(kind == 2));
        check("R8 corr_count", 32'(corr_count), 32'(exp_corr));
        check("R8 uncorr_count", 32'(uncorr_count), 32'(exp_uncorr));
        check("R7 sticky", 32'(err_sticky), 32'(exp_sticky));
    endtask

    function automatic logic [31:0] good_word(input logic [23:0] d);
        return {2'b00, tb_ecc(d), d};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [23:0] fx;
        int kind;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset outputs",
              {out_valid, out_corrected, out_uncorrectable, err_sticky,
               corr_count, uncorr_count, out_wc, out_vc, out_dt},
              '0);
        rst_n = 1'b1;

        // R1: field layout with a clean header
        send(good_word({16'hA55A, 2'b10, 6'h2B}), "R1 layout");
        check("R1 vc", 32'(out_vc), 32'h2);
        check("R1 dt", 32'(out_dt), 32'h2B);
        check("R1 wc", 32'(out_wc), 32'hA55A);

        // R6: idle cycle keeps fields, no strobe
        @(negedge clk);
        check("R6 idle valid", {out_valid, out_corrected, out_uncorrectable}, '0);
        check("R6 idle hold", 32'(out_wc), 32'hA55A);

        // R2: clean header, all zeros and all ones data
        send(good_word(24'h000000), "R2 clean zero");
        send(good_word(24'hFFFFFF), "R2 clean ones");

        // R3: each protected bit flipped in turn
        for (int i = 0; i < 24; i++) begin
            w = good_word(24'h3C96E1);
            w[i] = ~w[i];
            send(w, "R3 data flip");
            check("R3 repaired", {8'h0, out_wc, out_vc, out_dt}, 32'h3C96E1);
        end

        // R4: each check bit flipped in turn
        for (int k = 0; k < 6; k++) begin
            w = good_word(24'h5A0F33);
            w[24 + k] = ~w[24 + k];
            send(w, "R4 check flip");
            check("R4 data kept", {8'h0, out_wc, out_vc, out_dt}, 32'h5A0F33);
        end

        // R5: double flip of bit 0 and bit 29
        w = good_word(24'h123456);
        w[0] = ~w[0];
        w[29] = ~w[29];
        send(w, "R5 double flip");
        check("R5 unrepaired pulse", 32'(out_uncorrectable), 32'd1);

        // R10: unused top bits set on a clean header
        w = good_word(24'h0BEEF1) | 32'hC000_0000;
        send(w, "R10 top bits");
        check("R10 no pulse", {out_corrected, out_uncorrectable}, 2'b00);

        // R7: clear with data zero has no effect, data one clears
        @(negedge clk); clr_wr = 1'b1; clr_data = 1'b0;
        @(negedge clk); clr_wr = 1'b0;
        check("R7 clear data zero", 32'(err_sticky), 32'd1);
        clr_wr = 1'b1; clr_data = 1'b1;
        @(negedge clk); clr_wr = 1'b0; clr_data = 1'b0; exp_sticky = 1'b0;
        check("R7 clear one", 32'(err_sticky), 32'd0);

        // R7: uncorrectable header in the same cycle as a clear wins
        w = good_word(24'h777777);
        w[1] = ~w[1];
        w[2] = ~w[2];
        @(negedge clk);
        hdr_valid = 1'b1; hdr_word = w; clr_wr = 1'b1; clr_data = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0; clr_wr = 1'b0; clr_data = 1'b0;
        if (exp_uncorr < CMAX) exp_uncorr++;
        exp_sticky = 1'b1;
        check("R7 set beats clear", 32'(err_sticky), 32'd1);

        // Constrained random mix of clean, single, check-bit and double flips
        for (int n = 0; n < 200; n++) begin
            int mode, a, b;
            w = good_word(24'($urandom));
            w[31:30] = 2'($urandom);
            mode = int'($urandom % 4);
            a = int'($urandom % 30);
            b = (a + 1 + int'($urandom % 29)) % 30;
            case (mode)
                1: w[a % 24] = ~w[a % 24];
                2: w[24 + a % 6] = ~w[24 + a % 6];
                3: begin w[a] = ~w[a]; w[b] = ~w[b]; end
                default: ;
            endcase
            tb_model(w, kind, fx);
            if (mode == 3) check("R5 double is unrepairable", 32'(kind), 32'd2);
            send(w, "R2-R5 random");
        end

        // R8: counters saturate after many events
        for (int n = 0; n < CMAX + 2; n++) begin
            w = good_word(24'h00F00F);
            w[5] = ~w[5];
            send(w, "R8 saturate corr");
        end
        check("R8 corr saturated", 32'(corr_count), 32'(CMAX));
        check("R8 uncorr saturated", 32'(uncorr_count), 32'(CMAX));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule